// File: doc/BRIEF.md
# Go-Back-N Replay Transmitter

This block sits on the transmit side of a serial link, between a packet source and the link. Each 32-bit payload offered on the valid/ready input becomes a three-beat frame on the link output. The first beat is a header that carries a 12-bit sequence number. The second beat is the payload. The third beat is a 32-bit CRC computed over the header and the payload.

Every accepted payload stays in a small replay store until the far end acknowledges it. The far end returns its responses on a single-cycle input that carries a sequence number and a flag. The flag is low for a positive acknowledgement (ACK) and high for a negative one (NAK). An acknowledgement clears its own sequence number and every older one still held. A NAK, or a quiet period longer than the timeout while packets are held, makes the block resend every held packet, oldest first. New input is held off until that resend is complete.

The output is controlled by a four-state machine:
- IDLE either accepts a new packet or starts a pending replay.
- HDR emits the header beat.
- BODY emits the payload beat.
- TAIL emits the CRC beat.

The transitions are as follows:
- IDLE goes to HDR on an accepted input (*accept*) or on a replay start (*replay-start*).
- HDR goes to BODY when the beat is taken (*hdr-taken*).
- BODY goes to TAIL when the beat is taken (*body-taken*).
- TAIL goes back to HDR when a replay still has packets left (*replay-next*).
- TAIL goes to IDLE in every other case (*frame-done*).

Top module: `rtx_replay_tx`

## Requirements
- R1: Sequence numbers are assigned from 0 after reset and rise by one per accepted packet. Each frame is exactly three beats: a header with the sequence number in bits [11:0] and zeros in bits [31:12], then the payload, then the CRC. `out_last` is high on the CRC beat only.
- R2: The CRC beat is a CRC-32 with polynomial 0x04C11DB7 and seed 0xFFFFFFFF. It is computed most-significant bit first over the header word and then the payload word, and the final value is inverted.
- R3: An ACK carrying sequence N frees N and every older held entry. The test for "older" uses the modular distance from the oldest held entry. An acknowledgement whose number is outside the held window is ignored.
- R4: A NAK carrying sequence N first frees N and every older entry. It then resends all remaining held packets, oldest first, each with its original sequence number, payload and CRC.
- R5: If packets are held and no freeing acknowledgement arrives for TIMEOUT cycles, every held packet is resent, oldest first.
- R6: The timeout count restarts whenever an acknowledgement frees at least one entry. No count runs and no timeout resend happens while the store is empty.
- R7: At most DEPTH packets are held at once. When DEPTH packets are held, `in_ready` is low.
- R8: While a replay is pending or in progress, `in_ready` is low.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R10: Sequence numbers wrap from 4095 to 0.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source offers a payload |
| in_ready | output | 1 | Block accepts the payload |
| in_data | input | 32 | Payload word |
| out_valid | output | 1 | A link beat is present |
| out_ready | input | 1 | Link takes the beat |
| out_data | output | 32 | Header, payload or CRC beat |
| out_last | output | 1 | Marks the CRC beat |
| ack_valid | input | 1 | An acknowledgement is present this cycle |
| ack_nak | input | 1 | 1 = NAK, 0 = ACK |
| ack_seq | input | 12 | Sequence number being acknowledged |

## Verification
Payloads are sent with immediate acknowledgement and then left unacknowledged to fill the store. This separates correct framing and CRC from correct window accounting. The store is also filled exactly to capacity, followed by a stale acknowledgement and then a partial one. This shows whether the stall is lifted only by an acknowledgement inside the window.

Replays are triggered three ways: by a NAK, by timeout expiry, and by a timeout that is pushed back by a partial acknowledgement. Comparing the resent frames with the originals shows whether the replay starts at the right entry, and whether the count restarts or stops as it should. A long run past sequence 4095 checks the modular wrap.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
    localparam int SEQ_W  = 12;
    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C11DB7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_BODY,
        ST_TAIL
    } tx_state_e;

    // CRC over header word then payload word, MSB first, inverted result.
    function automatic logic [WORD_W-1:0] frame_crc(input logic [WORD_W-1:0] hdr,
                                                    input logic [WORD_W-1:0] pay);
        logic [2*WORD_W-1:0] stream;
        logic [WORD_W-1:0]   acc;
        logic                fb;
        stream = {hdr, pay};
        acc    = '1;
        for (int i = 2*WORD_W-1; i >= 0; i--) begin
            fb  = stream[i] ^ acc[WORD_W-1];
            acc = {acc[WORD_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return ~acc;
    endfunction
endpackage

// File: rtl/rtx_store.sv
module rtx_store #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/rtx_timer.sv
module rtx_timer #(
    parameter int LIMIT = 256,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);
    logic [CW-1:0] cnt_q;

    assign expire = run && !restart && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (!run || restart || expire) cnt_q <= '0;
        else                             cnt_q <= cnt_q + 1'b1;
    end

    AST_TMR_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !expire); // R6
    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> cnt_q == '0); // R5
endmodule

// File: rtl/rtx_replay_tx.sv
module rtx_replay_tx
    import rtx_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int TIMEOUT = 256,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last,
    input  logic              ack_valid,
    input  logic              ack_nak,
    input  logic [SEQ_W-1:0]  ack_seq
);
    tx_state_e state_q, state_d;

    logic [SEQ_W-1:0]  base_q, head_q, cur_q;
    logic              pend_q, rep_q;
    logic [SEQ_W-1:0]  held, ack_dist;
    logic              ack_free, empty, full, in_fire, start_rep;
    logic              frame_done, rep_last, expire;
    logic [WORD_W-1:0] hdr_word, rd_data, crc_word;

    assign held       = head_q - base_q;
    assign ack_dist   = ack_seq - base_q;
    assign ack_free   = ack_valid && (ack_dist < held);
    assign empty      = (held == '0);
    assign full       = (held == SEQ_W'(DEPTH));
    assign in_ready   = (state_q == ST_IDLE) && !pend_q && !rep_q && !full;
    assign in_fire    = in_valid && in_ready;
    assign start_rep  = (state_q == ST_IDLE) && pend_q && !empty;
    assign frame_done = (state_q == ST_TAIL) && out_ready;
    assign rep_last   = (cur_q + SEQ_W'(1)) == head_q;
    assign hdr_word   = {{(WORD_W-SEQ_W){1'b0}}, cur_q};
    assign crc_word   = frame_crc(hdr_word, rd_data);

    rtx_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
        .clk     (clk),
        .wr_en   (in_fire),
        .wr_idx  (head_q[AW-1:0]),
        .wr_data (in_data),
        .rd_idx  (cur_q[AW-1:0]),
        .rd_data (rd_data)
    );

    rtx_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!empty),
        .restart (ack_free),
        .expire  (expire)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_rep || in_fire) state_d = ST_HDR;
            ST_HDR:  if (out_ready) state_d = ST_BODY;
            ST_BODY: if (out_ready) state_d = ST_TAIL;
            ST_TAIL: if (out_ready) state_d = (rep_q && !rep_last) ? ST_HDR : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        out_valid = 1'b1;
        out_last  = 1'b0;
        out_data  = '0;
        unique case (state_q)
            ST_IDLE: out_valid = 1'b0;
            ST_HDR:  out_data  = hdr_word;
            ST_BODY: out_data  = rd_data;
            ST_TAIL: begin
                out_data = crc_word;
                out_last = 1'b1;
            end
            default: out_valid = 1'b0;
        endcase
    end

    // Window pointers and replay control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            head_q <= '0;
            cur_q  <= '0;
            pend_q <= 1'b0;
            rep_q  <= 1'b0;
        end else begin
            if (ack_free) base_q <= ack_seq + SEQ_W'(1);
            if (in_fire)  head_q <= head_q + SEQ_W'(1);

            if (in_fire)                           cur_q <= head_q;
            else if (start_rep)                    cur_q <= base_q;
            else if (frame_done && rep_q && !rep_last) cur_q <= cur_q + SEQ_W'(1);

            if (start_rep)                         rep_q <= 1'b1;
            else if (frame_done && rep_q && rep_last) rep_q <= 1'b0;

            if (expire || (ack_free && ack_nak))   pend_q <= 1'b1;
            else if (state_q == ST_IDLE && (start_rep || empty)) pend_q <= 1'b0;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        held <= SEQ_W'(DEPTH)); // R7
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !in_ready); // R7
    AST_REPLAY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_q || pend_q) |-> !in_ready); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |=> (head_q - $past(head_q)) == SEQ_W'(1)); // R10
    AST_LAST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last && out_ready) |=> !out_last); // R1
endmodule

// File: tb/rtx_replay_tx_test.sv
module rtx_replay_tx_test;
    localparam int DEPTH   = 8;
    localparam int TIMEOUT = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_last;
    logic        ack_valid = 1'b0;
    logic        ack_nak = 1'b0;
    logic [11:0] ack_seq = '0;

    int checks = 0;
    int errors = 0;
    logic [11:0] nseq = '0;
    logic [31:0] pay_hist [64];

    always #5 clk = ~clk;

    rtx_replay_tx #(.DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .ack_valid(ack_valid), .ack_nak(ack_nak), .ack_seq(ack_seq)
    );

    function automatic logic [31:0] ref_crc(input logic [31:0] w0, input logic [31:0] w1);
        logic [31:0] r = 32'hFFFF_FFFF;
        logic [31:0] words [2];
        words[0] = w0;
        words[1] = w1;
        foreach (words[k]) begin
            for (int b = 31; b >= 0; b--) begin
                if (words[k][b] != r[31]) r = (r << 1) ^ 32'h04C11DB7;
                else                      r = r << 1;
            end
        end
        return r ^ 32'hFFFF_FFFF;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_pkt(input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        pay_hist[nseq[5:0]] = d;
        nseq = nseq + 12'd1;
    endtask

    task automatic send_ack(input logic nak, input logic [11:0] s);
        @(negedge clk);
        ack_valid = 1'b1;
        ack_nak   = nak;
        ack_seq   = s;
        @(negedge clk);
        ack_valid = 1'b0;
        ack_nak   = 1'b0;
    endtask

    task automatic get_frame(input logic [11:0] s, input string tag);
        logic [31:0] d [3];
        logic        l [3];
        out_ready = 1'b1;
        for (int b = 0; b < 3; b++) begin
            while (!out_valid) @(negedge clk);
            d[b] = out_data;
            l[b] = out_last;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(d[0] == {20'h0, s}, {tag, " header"}, d[0], {20'h0, s});
        chk(d[1] == pay_hist[s[5:0]], {tag, " payload"}, d[1], pay_hist[s[5:0]]);
        chk(d[2] == ref_crc({20'h0, s}, pay_hist[s[5:0]]), "R2 crc", d[2],
            ref_crc({20'h0, s}, pay_hist[s[5:0]]));
        chk(!l[0] && !l[1] && l[2], "R1 last flag", {29'h0, l[0], l[1], l[2]}, 32'h1);
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (out_valid) seen = 1'b1;
        end
        chk(!seen, tag, {31'h0, seen}, 32'h0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11 out_valid", {31'h0, out_valid}, 32'h0);
        chk(in_ready == 1'b1, "R11 in_ready", {31'h0, in_ready}, 32'h1);
    endtask

    task automatic t_basic;
        logic [11:0] first = nseq;
        send_pkt(32'hDEAD_BEEF); get_frame(first, "R1");
        send_pkt(32'h0000_0000); get_frame(first + 12'd1, "R1");
        send_pkt(32'hFFFF_FFFF); get_frame(first + 12'd2, "R1");
        send_ack(1'b0, first + 12'd2);   // R3 cumulative: frees all three
        quiet(TIMEOUT + 50, "R6 no resend when empty");
    endtask

    task automatic t_full_nak;
        logic [11:0] b = nseq;
        for (int i = 0; i < DEPTH; i++) begin
            send_pkt(32'hA500_0000 + 32'(i));
            get_frame(b + 12'(i), "R1");
        end
        @(negedge clk);
        chk(in_ready == 1'b0, "R7 full stall", {31'h0, in_ready}, 32'h0);
        send_ack(1'b0, b - 12'd20);
        chk(in_ready == 1'b0, "R3 stale ack ignored", {31'h0, in_ready}, 32'h0);
        send_ack(1'b0, b + 12'd2);
        chk(in_ready == 1'b1, "R3 cumulative ack frees", {31'h0, in_ready}, 32'h1);
        send_ack(1'b1, b + 12'd4);
        chk(in_ready == 1'b0, "R8 blocked during replay", {31'h0, in_ready}, 32'h0);
        get_frame(b + 12'd5, "R4");
        get_frame(b + 12'd6, "R4");
        get_frame(b + 12'd7, "R4");
        send_ack(1'b0, b + 12'd7);
        @(negedge clk);
        chk(in_ready == 1'b1, "R8 ready after replay", {31'h0, in_ready}, 32'h1);
    endtask

    task automatic t_timeout;
        logic [11:0] b = nseq;
        send_pkt(32'h1234_5678); get_frame(b, "R1");
        send_pkt(32'h8765_4321); get_frame(b + 12'd1, "R1");
        quiet(TIMEOUT / 2, "R5 no early resend");
        get_frame(b, "R5");
        get_frame(b + 12'd1, "R5");
        send_ack(1'b0, b + 12'd1);
    endtask

    task automatic t_restart;
        logic [11:0] b = nseq;
        send_pkt(32'h0F0F_0F0F); get_frame(b, "R1");
        send_pkt(32'hF0F0_F0F0); get_frame(b + 12'd1, "R1");
        quiet(150, "R6 before partial ack");
        send_ack(1'b0, b);
        quiet(150, "R6 count restarted by ack");
        get_frame(b + 12'd1, "R6");
        send_ack(1'b0, b + 12'd1);
        quiet(TIMEOUT + 50, "R6 stopped when empty");
    endtask

    task automatic t_hold;
        logic [31:0] first;
        send_pkt(32'hCAFE_F00D);
        @(negedge clk);
        first = out_data;
        repeat (3) @(negedge clk);
        chk(out_valid && out_data == first, "R9 hold under backpressure", out_data, first);
        get_frame(nseq - 12'd1, "R9");
        send_ack(1'b0, nseq - 12'd1);
    endtask

    task automatic t_wrap;
        for (int i = 0; i < 4100; i++) begin
            send_pkt(32'h5A5A_0000 ^ 32'(i));
            get_frame(nseq - 12'd1, (nseq == 12'd1) ? "R10" : "R1");
            send_ack(1'b0, nseq - 12'd1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_full_nak();
        t_timeout();
        t_restart();
        t_hold();
        t_wrap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule